// File: doc/BRIEF.md
# Translation Context Selector

This block sits at the front of a two-stage radix address translator. For each access it decides how the effective address will be handled. It also selects the partition and process identifiers that the table walkers will use. In hypervisor real mode it produces the final real address itself. For a guest access that falls in a forbidden address quadrant it raises a segment fault, flavoured as instruction or data.

The caller supplies the effective address, the access kind, the machine mode bits and the context registers. It also supplies the permission and page-size results that each walk stage reports, so that the block can merge them into a single answer. Each request is accepted in one cycle. All results come out of one register stage, together with a one-cycle valid strobe.

Top module: `xlate_ctx_sel`

## Requirements
- R1: After reset, out_valid is 0 and every other output is 0.
- R2: A request with req_valid high produces out_valid high on exactly the next cycle. With no request, out_valid is 0 and all other outputs keep their values.
- R3: Access kind is encoded 0 = load, 1 = store, 2 = fetch, 3 = treated as load. Relocation is on for a fetch when instr_reloc is 1, and for any other kind when data_reloc is 1.
- R4: With hv_mode 1 and relocation off, the access is real mode. out_addr is req_ea with bits 63:60 cleared, ORed with rmor_reg when req_ea[63] is 0. out_real_en is 1, both stage enables are 0, the identifiers are 0, out_perm is 3'b111 and out_psize is all ones.
- R5: Outside real mode, with hv_mode 1, the quadrant req_ea[63:62] selects the identifiers as follows. Quadrant 0 gives partition 0 and pid_reg. Quadrant 1 gives lpid_reg and pid_reg. Quadrant 2 gives lpid_reg and process 0. Quadrant 3 gives partition 0 and process 0.
- R6: With hv_mode 0, quadrant 0 gives lpid_reg and pid_reg, and quadrant 3 gives lpid_reg and process 0.
- R7: With hv_mode 0, quadrants 1 and 2 raise out_seg_fault. out_seg_instr is 1 for a fetch and 0 otherwise. out_fault_addr is req_ea for data accesses and 0 for a fetch. Enables, identifiers, address and out_perm are 0.
- R8: out_proc_en is 1 exactly when relocation is on and the access neither faults nor is real mode.
- R9: out_part_en is 1 for a non-faulting, non-real access when the selected partition is nonzero or hv_mode is 0.
- R10: For a non-faulting, non-real access, out_addr is req_ea with bits 63:62 cleared.
- R11: For a non-faulting, non-real access, the permission bits (bit 0 read, bit 1 write, bit 2 execute) are the AND of the permissions of the enabled stages. out_psize is the minimum of their page sizes, with process stage = stg1 and partition stage = stg2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ea | input | EA_W | Effective address |
| req_acc | input | 2 | Access kind |
| hv_mode | input | 1 | Hypervisor state |
| instr_reloc | input | 1 | Instruction relocation enable |
| data_reloc | input | 1 | Data relocation enable |
| lpid_reg | input | LPID_W | Current partition identifier |
| pid_reg | input | PID_W | Current process identifier |
| rmor_reg | input | EA_W | Real-mode offset |
| stg1_perm | input | 3 | Process-stage permissions |
| stg1_psize | input | PSZ_W | Process-stage page size (log2) |
| stg2_perm | input | 3 | Partition-stage permissions |
| stg2_psize | input | PSZ_W | Partition-stage page size (log2) |
| out_valid | output | 1 | Result strobe |
| out_lpid | output | LPID_W | Selected partition |
| out_pid | output | PID_W | Selected process |
| out_proc_en | output | 1 | Process-scoped walk needed |
| out_part_en | output | 1 | Partition-scoped walk needed |
| out_real_en | output | 1 | Real-mode result, no walk |
| out_addr | output | EA_W | Real or guest-real address |
| out_seg_fault | output | 1 | Segment fault raised |
| out_seg_instr | output | 1 | Fault is the instruction flavour |
| out_fault_addr | output | EA_W | Recorded data fault address |
| out_perm | output | 3 | Merged permissions |
| out_psize | output | PSZ_W | Merged page size |

## Verification
All results pass through a single register stage, so a wrong next-state value appears at the ports one cycle after the request that caused it. A wrong held value appears on any idle cycle that follows. Because the bench compares every output on every clock, a mis-decoded quadrant is caught at once, as is a swapped relocation bit or a stale register. A misplaced mode term shows up as a wrong identifier, enable or address on the very next sample. The sweep covers every combination of mode, quadrant, access kind and relocation bits, with both zero and nonzero partitions.

// File: rtl/xcs_pkg.sv
package xcs_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    localparam logic [2:0] PERM_ALL = 3'b111;

endpackage

// File: rtl/xcs_quad_map.sv
module xcs_quad_map #(
    parameter int LPID_W = 12,
    parameter int PID_W  = 20
) (
    input  logic [1:0]        quad,
    input  logic              hv,
    input  logic [LPID_W-1:0] lpid_reg,
    input  logic [PID_W-1:0]  pid_reg,
    output logic [LPID_W-1:0] sel_lpid,
    output logic [PID_W-1:0]  sel_pid,
    output logic              illegal
);

    always_comb begin
        sel_lpid = '0;
        sel_pid  = '0;
        illegal  = 1'b0;
        if (hv) begin
            unique case (quad)
                2'd0: sel_pid = pid_reg;
                2'd1: begin
                    sel_lpid = lpid_reg;
                    sel_pid  = pid_reg;
                end
                2'd2: sel_lpid = lpid_reg;
                default: ;
            endcase
        end else begin
            unique case (quad)
                2'd0: begin
                    sel_lpid = lpid_reg;
                    sel_pid  = pid_reg;
                end
                2'd3: sel_lpid = lpid_reg;
                default: illegal = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/xcs_real_addr.sv
module xcs_real_addr #(
    parameter int EA_W = 64
) (
    input  logic [EA_W-1:0] ea,
    input  logic [EA_W-1:0] rmor,
    output logic [EA_W-1:0] raddr
);

    localparam int IGN_BITS = 4;
    localparam int KEEP_W   = EA_W - IGN_BITS;

    logic [EA_W-1:0] trimmed;

    always_comb begin
        trimmed = {{IGN_BITS{1'b0}}, ea[KEEP_W-1:0]};
        raddr   = ea[EA_W-1] ? trimmed : (trimmed | rmor);
    end

endmodule

// File: rtl/xcs_stage_merge.sv
module xcs_stage_merge #(
    parameter int PSZ_W = 6
) (
    input  logic             proc_en,
    input  logic             part_en,
    input  logic [2:0]       p1_perm,
    input  logic [PSZ_W-1:0] p1_size,
    input  logic [2:0]       p2_perm,
    input  logic [PSZ_W-1:0] p2_size,
    output logic [2:0]       perm,
    output logic [PSZ_W-1:0] psize
);

    import xcs_pkg::*;

    always_comb begin
        perm  = PERM_ALL;
        psize = '1;
        if (proc_en) begin
            perm  = perm & p1_perm;
            psize = p1_size;
        end
        if (part_en) begin
            perm = perm & p2_perm;
            if (p2_size < psize) begin
                psize = p2_size;
            end
        end
    end

endmodule

// File: rtl/xlate_ctx_sel.sv
module xlate_ctx_sel #(
    parameter int EA_W   = 64,
    parameter int LPID_W = 12,
    parameter int PID_W  = 20,
    parameter int PSZ_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [EA_W-1:0]   req_ea,
    input  logic [1:0]        req_acc,
    input  logic              hv_mode,
    input  logic              instr_reloc,
    input  logic              data_reloc,
    input  logic [LPID_W-1:0] lpid_reg,
    input  logic [PID_W-1:0]  pid_reg,
    input  logic [EA_W-1:0]   rmor_reg,
    input  logic [2:0]        stg1_perm,
    input  logic [PSZ_W-1:0]  stg1_psize,
    input  logic [2:0]        stg2_perm,
    input  logic [PSZ_W-1:0]  stg2_psize,
    output logic              out_valid,
    output logic [LPID_W-1:0] out_lpid,
    output logic [PID_W-1:0]  out_pid,
    output logic              out_proc_en,
    output logic              out_part_en,
    output logic              out_real_en,
    output logic [EA_W-1:0]   out_addr,
    output logic              out_seg_fault,
    output logic              out_seg_instr,
    output logic [EA_W-1:0]   out_fault_addr,
    output logic [2:0]        out_perm,
    output logic [PSZ_W-1:0]  out_psize
);

    import xcs_pkg::*;

    localparam int QUAD_HI = EA_W - 1;
    localparam int LOW_W   = EA_W - 2;

    typedef struct packed {
        logic              valid;
        logic [LPID_W-1:0] lpid;
        logic [PID_W-1:0]  pid;
        logic              proc_en;
        logic              part_en;
        logic              real_en;
        logic [EA_W-1:0]   addr;
        logic              seg_fault;
        logic              seg_instr;
        logic [EA_W-1:0]   fault_addr;
        logic [2:0]        perm;
        logic [PSZ_W-1:0]  psize;
    } ctx_state_t;

    ctx_state_t st_d, st_q;

    logic              is_fetch;
    logic              reloc;
    logic              real_mode;
    logic [LPID_W-1:0] map_lpid;
    logic [PID_W-1:0]  map_pid;
    logic              map_illegal;
    logic [EA_W-1:0]   real_addr;
    logic              want_proc;
    logic              want_part;
    logic [2:0]        mrg_perm;
    logic [PSZ_W-1:0]  mrg_psize;

    xcs_quad_map #(.LPID_W(LPID_W), .PID_W(PID_W)) u_quad (
        .quad     (req_ea[QUAD_HI -: 2]),
        .hv       (hv_mode),
        .lpid_reg (lpid_reg),
        .pid_reg  (pid_reg),
        .sel_lpid (map_lpid),
        .sel_pid  (map_pid),
        .illegal  (map_illegal)
    );

    xcs_real_addr #(.EA_W(EA_W)) u_real (
        .ea    (req_ea),
        .rmor  (rmor_reg),
        .raddr (real_addr)
    );

    xcs_stage_merge #(.PSZ_W(PSZ_W)) u_merge (
        .proc_en (want_proc),
        .part_en (want_part),
        .p1_perm (stg1_perm),
        .p1_size (stg1_psize),
        .p2_perm (stg2_perm),
        .p2_size (stg2_psize),
        .perm    (mrg_perm),
        .psize   (mrg_psize)
    );

    always_comb begin
        is_fetch  = (req_acc == ACC_FETCH);
        reloc     = is_fetch ? instr_reloc : data_reloc;
        real_mode = hv_mode && !reloc;
        want_proc = reloc;
        want_part = (map_lpid != '0) || !hv_mode;

        st_d       = st_q;
        st_d.valid = 1'b0;
        if (req_valid) begin
            st_d = '0;
            st_d.valid = 1'b1;
            if (real_mode) begin
                st_d.real_en = 1'b1;
                st_d.addr    = real_addr;
                st_d.perm    = PERM_ALL;
                st_d.psize   = '1;
            end else if (map_illegal) begin
                st_d.seg_fault  = 1'b1;
                st_d.seg_instr  = is_fetch;
                st_d.fault_addr = is_fetch ? '0 : req_ea;
            end else begin
                st_d.lpid    = map_lpid;
                st_d.pid     = map_pid;
                st_d.proc_en = want_proc;
                st_d.part_en = want_part;
                st_d.addr    = {2'b00, req_ea[LOW_W-1:0]};
                st_d.perm    = mrg_perm;
                st_d.psize   = mrg_psize;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid      = st_q.valid;
    assign out_lpid       = st_q.lpid;
    assign out_pid        = st_q.pid;
    assign out_proc_en    = st_q.proc_en;
    assign out_part_en    = st_q.part_en;
    assign out_real_en    = st_q.real_en;
    assign out_addr       = st_q.addr;
    assign out_seg_fault  = st_q.seg_fault;
    assign out_seg_instr  = st_q.seg_instr;
    assign out_fault_addr = st_q.fault_addr;
    assign out_perm       = st_q.perm;
    assign out_psize      = st_q.psize;

    // R2
    strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    // R2
    strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(req_valid));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(out_addr) && $stable(out_lpid) && $stable(out_pid)));

    // R7
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_seg_fault |-> (!out_proc_en && !out_part_en && !out_real_en && out_perm == 3'b000));

    // R4
    real_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_real_en |-> (!out_proc_en && !out_part_en && !out_seg_fault));

    // R10
    quad_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_real_en && !out_seg_fault) |-> (out_addr[QUAD_HI -: 2] == 2'b00));

    // R9
    part_need_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_real_en && !out_seg_fault && out_lpid == '0 && $past(hv_mode))
            |-> !out_part_en);

    // R7
    fault_flavour_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_seg_fault && out_seg_instr) |-> (out_fault_addr == '0));

endmodule

// File: tb/xlate_ctx_sel_bench.sv
module xlate_ctx_sel_bench;

    localparam int EA_W   = 64;
    localparam int LPID_W = 12;
    localparam int PID_W  = 20;
    localparam int PSZ_W  = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [EA_W-1:0]   req_ea = '0;
    logic [1:0]        req_acc = '0;
    logic              hv_mode = 1'b0;
    logic              instr_reloc = 1'b0;
    logic              data_reloc = 1'b0;
    logic [LPID_W-1:0] lpid_reg = '0;
    logic [PID_W-1:0]  pid_reg = '0;
    logic [EA_W-1:0]   rmor_reg = '0;
    logic [2:0]        stg1_perm = '0;
    logic [PSZ_W-1:0]  stg1_psize = '0;
    logic [2:0]        stg2_perm = '0;
    logic [PSZ_W-1:0]  stg2_psize = '0;
    logic              out_valid;
    logic [LPID_W-1:0] out_lpid;
    logic [PID_W-1:0]  out_pid;
    logic              out_proc_en;
    logic              out_part_en;
    logic              out_real_en;
    logic [EA_W-1:0]   out_addr;
    logic              out_seg_fault;
    logic              out_seg_instr;
    logic [EA_W-1:0]   out_fault_addr;
    logic [2:0]        out_perm;
    logic [PSZ_W-1:0]  out_psize;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    xlate_ctx_sel u_xlate_ctx_sel (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea),
        .req_acc(req_acc), .hv_mode(hv_mode), .instr_reloc(instr_reloc),
        .data_reloc(data_reloc), .lpid_reg(lpid_reg), .pid_reg(pid_reg),
        .rmor_reg(rmor_reg), .stg1_perm(stg1_perm), .stg1_psize(stg1_psize),
        .stg2_perm(stg2_perm), .stg2_psize(stg2_psize), .out_valid(out_valid),
        .out_lpid(out_lpid), .out_pid(out_pid), .out_proc_en(out_proc_en),
        .out_part_en(out_part_en), .out_real_en(out_real_en), .out_addr(out_addr),
        .out_seg_fault(out_seg_fault), .out_seg_instr(out_seg_instr),
        .out_fault_addr(out_fault_addr), .out_perm(out_perm), .out_psize(out_psize)
    );

    // expected values, held between requests
    logic [63:0] e_valid, e_lpid, e_pid, e_proc, e_part, e_real, e_addr;
    logic [63:0] e_fault, e_finstr, e_faddr, e_perm, e_psize;
    string t_id, t_addr;

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input bit at_reset);
        string ti, ta;
        ti = at_reset ? "R1" : t_id;
        ta = at_reset ? "R1" : t_addr;
        chk(at_reset ? "R1" : "R2", "valid", {63'd0, out_valid}, e_valid);
        chk(ti, "lpid", {52'd0, out_lpid}, e_lpid);
        chk(ti, "pid", {44'd0, out_pid}, e_pid);
        chk(at_reset ? "R1" : "R3 R8", "proc_en", {63'd0, out_proc_en}, e_proc);
        chk(at_reset ? "R1" : "R9", "part_en", {63'd0, out_part_en}, e_part);
        chk(at_reset ? "R1" : "R4", "real_en", {63'd0, out_real_en}, e_real);
        chk(ta, "addr", out_addr, e_addr);
        chk(at_reset ? "R1" : "R7", "seg_fault", {63'd0, out_seg_fault}, e_fault);
        chk(at_reset ? "R1" : "R7", "seg_instr", {63'd0, out_seg_instr}, e_finstr);
        chk(at_reset ? "R1" : "R7", "fault_addr", out_fault_addr, e_faddr);
        chk(at_reset ? "R1" : "R11", "perm", {61'd0, out_perm}, e_perm);
        chk(at_reset ? "R1" : "R11", "psize", {58'd0, out_psize}, e_psize);
    endtask

    // behavioural reference for one request
    task automatic model_request();
        bit fetch, rel;
        int q;
        logic [63:0] ra, p, s;
        fetch = (req_acc == 2'd2);
        rel = fetch ? instr_reloc : data_reloc;
        q = int'(req_ea[63:62]);
        e_valid = 1; e_lpid = 0; e_pid = 0; e_proc = 0; e_part = 0; e_real = 0;
        e_addr = 0; e_fault = 0; e_finstr = 0; e_faddr = 0; e_perm = 0; e_psize = 0;
        t_id = hv_mode ? "R5" : "R6";
        t_addr = "R10";
        if (hv_mode && !rel) begin
            t_addr = "R4"; t_id = "R4";
            ra = req_ea & 64'h0FFF_FFFF_FFFF_FFFF;
            if (req_ea[63] == 1'b0) ra = ra | rmor_reg;
            e_real = 1; e_addr = ra; e_perm = 7; e_psize = 63;
        end else if (!hv_mode && (q == 1 || q == 2)) begin
            t_id = "R7"; t_addr = "R7";
            e_fault = 1; e_finstr = fetch;
            e_faddr = fetch ? 64'd0 : req_ea;
        end else begin
            if (hv_mode) begin
                if (q == 1 || q == 2) e_lpid = lpid_reg;
                if (q == 0 || q == 1) e_pid = pid_reg;
            end else begin
                e_lpid = lpid_reg;
                if (q == 0) e_pid = pid_reg;
            end
            e_proc = rel;
            e_part = (e_lpid != 0) || !hv_mode;
            e_addr = {2'b00, req_ea[61:0]};
            p = 7; s = 63;
            if (e_proc) begin p = p & stg1_perm; s = stg1_psize; end
            if (e_part) begin
                p = p & stg2_perm;
                if (stg2_psize < s) s = stg2_psize;
            end
            e_perm = p; e_psize = s;
        end
    endtask

    task automatic step(input bit valid);
        req_valid = valid;
        if (valid) model_request();
        else e_valid = 0;
        @(negedge clk);
        compare_all(1'b0);
    endtask

    task automatic rand_ctx();
        lpid_reg   = LPID_W'($urandom);
        pid_reg    = PID_W'($urandom);
        rmor_reg   = {$urandom, $urandom};
        stg1_perm  = 3'($urandom);
        stg2_perm  = 3'($urandom);
        stg1_psize = PSZ_W'($urandom_range(12, 40));
        stg2_psize = PSZ_W'($urandom_range(12, 40));
    endtask

    initial begin
        e_valid = 0; e_lpid = 0; e_pid = 0; e_proc = 0; e_part = 0; e_real = 0;
        e_addr = 0; e_fault = 0; e_finstr = 0; e_faddr = 0; e_perm = 0; e_psize = 0;
        t_id = "R1"; t_addr = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all(1'b1);  // R1 reset state
        // exhaustive sweep of mode, quadrant, access kind and relocation bits
        for (int h = 0; h < 2; h++) begin
            for (int q = 0; q < 4; q++) begin
                for (int a = 0; a < 4; a++) begin
                    for (int r = 0; r < 4; r++) begin
                        rand_ctx();
                        if (r[0]) lpid_reg = '0;  // R9 zero-partition case
                        hv_mode = h[0];
                        instr_reloc = r[0];
                        data_reloc = r[1];
                        req_acc = a[1:0];
                        req_ea = {q[1:0], 62'($urandom) ^ {30'd0, $urandom}};
                        step(1'b1);
                    end
                end
            end
        end
        // R4 both settings of the top address bit, fixed offset
        hv_mode = 1; instr_reloc = 0; data_reloc = 0; req_acc = 2'd1;
        rmor_reg = 64'h0000_0000_4000_0000;
        req_ea = 64'h7123_0000_0000_1234; step(1'b1);
        req_ea = 64'hF123_0000_0000_1234; step(1'b1);
        // R2 idle cycles hold the previous result with the strobe low
        req_ea = 64'h0; rmor_reg = 64'hFFFF; step(1'b0); step(1'b0);
        // random traffic with gaps
        for (int i = 0; i < 400; i++) begin
            rand_ctx();
            hv_mode = 1'($urandom);
            instr_reloc = 1'($urandom);
            data_reloc = 1'($urandom);
            req_acc = 2'($urandom);
            req_ea = {$urandom, $urandom};
            step(($urandom % 4) != 0);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule